// File: doc/BRIEF.md
# Packet Stream Width Up-Converter

This block takes a framed packet stream on a narrow bus (64 or 128 bits per beat) and re-emits it on a wider bus (up to 512 bits). Handshakes use valid/ready, with a last flag on the final beat of each packet and a user sideband that is constant across a packet. Packing is not a plain concatenation of beats. The 64-bit header at the start of each packet is decoded. Its metadata-count and length fields are rewritten for the wider word. A separate timestamp beat is folded into the header word. Metadata and payload are each packed into wide words on their own, and management packets keep one beat in for one beat out.

A typical use is between a narrow producer and a wide switch fabric. The output stage is a single register, and its valid never depends on the downstream ready. This lets one input beat be accepted on every cycle in which the output register is empty or is being drained. When the two widths are configured equal, the block reduces to wires.

Top module: `pkt_widen`

## Requirements
- R1: The header is the low 64 bits of the first beat: length in bytes at [15:0], metadata word count at [20:16], packet type at [23:21], and bits [63:24] carried through unchanged. On output, the metadata count becomes ceil(count_in × IN_W / OUT_W).
- R2: For packet types other than management, the output length is OUT_W/8 × (1 + metadata count out) plus the payload bytes. The payload bytes are the input length minus the input header, timestamp and metadata bytes.
- R3: Type 3'd7 marks timestamped data. With a 64-bit input, the timestamp is the beat after the header. On output it sits in bits [127:64] of the header word, with the bits above zero.
- R4: Metadata words are packed with the earliest word in the lowest bits. Lanes in the final metadata output word that have no input word are zero, and metadata never shares an output word with the header or the payload.
- R5: Payload words are packed the same way, starting at a fresh output word. The output word holding the last input beat carries the last flag, and its unfilled lanes are zero.
- R6: Type 3'd1 marks management packets. Each payload beat becomes exactly one output word, zero-extended. Their length counts ceil(payload bytes / (IN_W/8)) × OUT_W/8 for the payload.
- R7: In the first payload word of a management packet, bits [47:45] are replaced by the output width code (0 = 64, 1 = 128, 2 = 256, 3 = 512 bits).
- R8: Every output beat of a packet carries the user value presented with that packet.
- R9: Once output valid is high, it stays high with data, last and user held until ready is seen. Input ready is high whenever the output register is empty. With no stalls on either side, a packet of k input beats is accepted in k cycles.
- R10: While reset is low and after it is released, output valid is low and input ready is high.
- R11: When IN_W equals OUT_W, every output equals the corresponding input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_data | input | IN_W | Narrow input beat |
| i_user | input | USER_W | Per-packet user sideband, input side |
| i_last | input | 1 | Final beat of the input packet |
| i_valid | input | 1 | Input beat valid |
| i_ready | output | 1 | Input beat accepted when high with valid |
| o_data | output | OUT_W | Wide output beat |
| o_user | output | USER_W | Per-packet user sideband, output side |
| o_last | output | 1 | Final beat of the output packet |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream ready |

## Verification
The sweep crosses the three handled packet types with metadata counts of 0, 1, 3, 4, 5, 8 and 31 and payloads of 1 to 9 beats, using 64-bit in and 256-bit out. Counts that are exact multiples of four, one over a multiple and below four tell full packing apart from zero-filled partial words in both metadata and payload. The final payload byte count varies, which separates byte-exact lengths from the rounded management lengths. The whole sweep is repeated with no stalls, input-only stalls, output-only stalls and both, which exposes lost or duplicated beats under backpressure and measures single-cycle throughput. A second instance with equal widths, fed the same stream, checks the pass-through case.

// File: rtl/pkt_widen_pkg.sv
package pkt_widen_pkg;
    localparam int HDR_LEN_LSB = 0;
    localparam int HDR_MD_LSB  = 16;
    localparam int HDR_TY_LSB  = 21;

    localparam logic [2:0] TY_MGMT    = 3'd1;
    localparam logic [2:0] TY_DATA    = 3'd6;
    localparam logic [2:0] TY_DATA_TS = 3'd7;

    localparam int WCODE_LSB = 45;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_TS   = 2'd1,
        ST_META = 2'd2,
        ST_PAY  = 2'd3
    } phase_e;

    function automatic logic [2:0] width_code(input int w);
        return 3'($clog2(w / 64));
    endfunction
endpackage

// File: rtl/pkt_hdr_rewrite.sv
module pkt_hdr_rewrite
    import pkt_widen_pkg::*;
#(
    parameter int IN_W  = 64,
    parameter int OUT_W = 256
) (
    input  logic [63:0] hdr_i,
    output logic [63:0] hdr_o,
    output logic        is_ts,
    output logic        is_mgmt,
    output logic [4:0]  mcnt
);
    localparam int          RATIO  = OUT_W / IN_W;
    localparam logic [15:0] IN_B   = 16'(IN_W / 8);
    localparam logic [15:0] OUT_B  = 16'(OUT_W / 8);
    localparam logic [15:0] RAT16  = 16'(RATIO);
    localparam logic        TS_SEP = (IN_W == 64);

    logic [2:0]  ty;
    logic [15:0] len_in, m16, mo16, pre16, pay16, payw16, len_out;

    always_comb begin
        ty      = hdr_i[HDR_TY_LSB +: 3];
        mcnt    = hdr_i[HDR_MD_LSB +: 5];
        len_in  = hdr_i[HDR_LEN_LSB +: 16];
        is_ts   = (ty == TY_DATA_TS);
        is_mgmt = (ty == TY_MGMT);
        m16     = {11'd0, mcnt};
        mo16    = (m16 + RAT16 - 16'd1) / RAT16;
        pre16   = IN_B * (16'd1 + {15'd0, is_ts & TS_SEP} + m16);
        pay16   = len_in - pre16;
        payw16  = (pay16 + IN_B - 16'd1) / IN_B;
        len_out = OUT_B * (16'd1 + mo16) + (is_mgmt ? payw16 * OUT_B : pay16);
        hdr_o   = hdr_i;
        hdr_o[HDR_MD_LSB +: 5]   = mo16[4:0];
        hdr_o[HDR_LEN_LSB +: 16] = len_out;
    end
endmodule

// File: rtl/pkt_widen_core.sv
module pkt_widen_core
    import pkt_widen_pkg::*;
#(
    parameter int IN_W   = 64,
    parameter int OUT_W  = 256,
    parameter int USER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   i_data,
    input  logic [USER_W-1:0] i_user,
    input  logic              i_last,
    input  logic              i_valid,
    output logic              i_ready,
    input  logic [63:0]       hdr_new,
    input  logic              is_ts,
    input  logic              is_mgmt,
    input  logic [4:0]        mcnt,
    output logic [OUT_W-1:0]  o_data,
    output logic [USER_W-1:0] o_user,
    output logic              o_last,
    output logic              o_valid,
    input  logic              o_ready
);
    localparam int         RATIO  = OUT_W / IN_W;
    localparam int         LANE_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic       TS_SEP = (IN_W == 64);
    localparam logic [2:0] WCODE  = width_code(OUT_W);

    typedef struct packed {
        phase_e            ph;
        logic [LANE_W-1:0] lane;
        logic [OUT_W-1:0]  acc;
        logic [4:0]        mleft;
        logic              mgmt;
        logic              first;
        logic [USER_W-1:0] user;
        logic              ov;
        logic [OUT_W-1:0]  od;
        logic              ol;
        logic [USER_W-1:0] ou;
    } state_t;

    state_t q, d;

    logic              fire, lane_full, emit, el;
    logic [OUT_W-1:0]  ext, merged, hw, ew;
    logic [USER_W-1:0] eu;

    assign i_ready = !q.ov || o_ready;

    always_comb begin
        fire      = i_valid && i_ready;
        ext       = OUT_W'(i_data);
        merged    = q.acc | (ext << (32'(q.lane) * IN_W));
        lane_full = (q.lane == LANE_W'(RATIO - 1));
        hw        = '0;
        hw[63:0]  = hdr_new;
        if (is_ts) hw[127:64] = ext[127:64];
        d    = q;
        emit = 1'b0;
        ew   = '0;
        el   = 1'b0;
        eu   = q.user;
        if (q.ov && o_ready) d.ov = 1'b0;
        if (fire) begin
            unique case (q.ph)
                ST_HDR: begin
                    d.user  = i_user;
                    d.mgmt  = is_mgmt;
                    d.mleft = mcnt;
                    d.first = 1'b1;
                    d.lane  = '0;
                    if (is_ts && TS_SEP) begin
                        d.acc = hw;
                        d.ph  = ST_TS;
                    end else begin
                        emit  = 1'b1;
                        ew    = hw;
                        eu    = i_user;
                        d.acc = '0;
                        d.ph  = (mcnt != 5'd0) ? ST_META : ST_PAY;
                    end
                end
                ST_TS: begin
                    emit  = 1'b1;
                    ew    = q.acc | (ext << 64);
                    d.acc = '0;
                    d.ph  = (q.mleft != 5'd0) ? ST_META : ST_PAY;
                end
                ST_META: begin
                    d.mleft = q.mleft - 5'd1;
                    if (lane_full || q.mleft == 5'd1) begin
                        emit   = 1'b1;
                        ew     = merged;
                        d.acc  = '0;
                        d.lane = '0;
                    end else begin
                        d.acc  = merged;
                        d.lane = q.lane + LANE_W'(1);
                    end
                    if (q.mleft == 5'd1) d.ph = ST_PAY;
                end
                ST_PAY: begin
                    if (q.mgmt) begin
                        emit = 1'b1;
                        ew   = ext;
                        if (q.first) ew[WCODE_LSB +: 3] = WCODE;
                        el   = i_last;
                    end else if (lane_full || i_last) begin
                        emit   = 1'b1;
                        ew     = merged;
                        el     = i_last;
                        d.acc  = '0;
                        d.lane = '0;
                    end else begin
                        d.acc  = merged;
                        d.lane = q.lane + LANE_W'(1);
                    end
                    d.first = 1'b0;
                    if (i_last) begin
                        d.ph   = ST_HDR;
                        d.acc  = '0;
                        d.lane = '0;
                    end
                end
                default: d.ph = ST_HDR;
            endcase
        end
        if (emit) begin
            d.ov = 1'b1;
            d.od = ew;
            d.ol = el;
            d.ou = eu;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign o_valid = q.ov;
    assign o_data  = q.od;
    assign o_last  = q.ol;
    assign o_user  = q.ou;
endmodule

// File: rtl/pkt_widen.sv
module pkt_widen #(
    parameter int IN_W   = 64,
    parameter int OUT_W  = 256,
    parameter int USER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   i_data,
    input  logic [USER_W-1:0] i_user,
    input  logic              i_last,
    input  logic              i_valid,
    output logic              i_ready,
    output logic [OUT_W-1:0]  o_data,
    output logic [USER_W-1:0] o_user,
    output logic              o_last,
    output logic              o_valid,
    input  logic              o_ready
);
    generate
        if (IN_W == OUT_W) begin : g_pass
            assign o_data  = i_data;
            assign o_user  = i_user;
            assign o_last  = i_last;
            assign o_valid = i_valid;
            assign i_ready = o_ready;
        end else begin : g_widen
            logic [63:0] hdr_new;
            logic        is_ts, is_mgmt;
            logic [4:0]  mcnt;

            pkt_hdr_rewrite #(.IN_W(IN_W), .OUT_W(OUT_W)) u_hdr (
                .hdr_i   (i_data[63:0]),
                .hdr_o   (hdr_new),
                .is_ts   (is_ts),
                .is_mgmt (is_mgmt),
                .mcnt    (mcnt)
            );

            pkt_widen_core #(.IN_W(IN_W), .OUT_W(OUT_W), .USER_W(USER_W)) u_core (
                .clk     (clk),
                .rst_n   (rst_n),
                .i_data  (i_data),
                .i_user  (i_user),
                .i_last  (i_last),
                .i_valid (i_valid),
                .i_ready (i_ready),
                .hdr_new (hdr_new),
                .is_ts   (is_ts),
                .is_mgmt (is_mgmt),
                .mcnt    (mcnt),
                .o_data  (o_data),
                .o_user  (o_user),
                .o_last  (o_last),
                .o_valid (o_valid),
                .o_ready (o_ready)
            );
        end
    endgenerate
endmodule

// File: rtl/pkt_widen_chk.sv
module pkt_widen_chk #(
    parameter int OUT_W  = 256,
    parameter int USER_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              i_valid,
    input logic              i_ready,
    input logic [OUT_W-1:0]  o_data,
    input logic [USER_W-1:0] o_user,
    input logic              o_last,
    input logic              o_valid,
    input logic              o_ready
);
    logic              mid_q;
    logic [USER_W-1:0] user_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q  <= 1'b0;
            user_q <= '0;
        end else if (o_valid && o_ready) begin
            mid_q  <= !o_last;
            user_q <= o_user;
        end
    end

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_ready |=> o_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_ready |=> $stable(o_data) && $stable(o_last) && $stable(o_user));

    // R9
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> i_ready);

    // R8
    user_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_q && o_valid |-> o_user == user_q);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !o_valid || $past(i_valid));
endmodule

bind pkt_widen pkt_widen_chk #(.OUT_W(OUT_W), .USER_W(USER_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .i_ready (i_ready),
    .o_data  (o_data),
    .o_user  (o_user),
    .o_last  (o_last),
    .o_valid (o_valid),
    .o_ready (o_ready)
);

// File: tb/pkt_widen_bench.sv
`timescale 1ns/100ps
module pkt_widen_bench;
    localparam int IN_W = 64, OUT_W = 256, USER_W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [IN_W-1:0]   i_data = '0;
    logic [USER_W-1:0] i_user = '0;
    logic              i_last = 1'b0, i_valid = 1'b0, i_ready;
    logic [OUT_W-1:0]  o_data;
    logic [USER_W-1:0] o_user;
    logic              o_last, o_valid, o_ready = 1'b1;

    logic [IN_W-1:0]   p_data;
    logic [USER_W-1:0] p_user;
    logic              p_last, p_valid, p_ready;

    pkt_widen #(.IN_W(IN_W), .OUT_W(OUT_W), .USER_W(USER_W)) u_pkt_widen (
        .clk(clk), .rst_n(rst_n), .i_data(i_data), .i_user(i_user), .i_last(i_last),
        .i_valid(i_valid), .i_ready(i_ready), .o_data(o_data), .o_user(o_user),
        .o_last(o_last), .o_valid(o_valid), .o_ready(o_ready));

    pkt_widen #(.IN_W(IN_W), .OUT_W(IN_W), .USER_W(USER_W)) u_pkt_widen_pass (
        .clk(clk), .rst_n(rst_n), .i_data(i_data), .i_user(i_user), .i_last(i_last),
        .i_valid(i_valid), .i_ready(p_ready), .o_data(p_data), .o_user(p_user),
        .o_last(p_last), .o_valid(p_valid), .o_ready(1'b1));

    int checks = 0, fails = 0, pass_err = 0;
    int in_stall = 0, out_stall = 0;
    bit done = 0;

    logic [OUT_W-1:0]  exp_d[$], got_d[$];
    logic              exp_l[$], got_l[$];
    logic [USER_W-1:0] exp_u[$], got_u[$];
    string             exp_t[$];

    task automatic chk(input bit ok, input string req, input logic [OUT_W-1:0] act,
                       input logic [OUT_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] dw(input int p, input int i);
        return {32'hA5C30000 ^ 32'(p * 977), 16'(i), 16'(p)};
    endfunction

    always @(negedge clk) begin
        if (out_stall > 0 && $urandom_range(0, 99) < out_stall) o_ready = 1'b0;
        else o_ready = 1'b1;
        if (rst_n && o_valid && o_ready) begin
            got_d.push_back(o_data);
            got_l.push_back(o_last);
            got_u.push_back(o_user);
        end
        if (rst_n && (p_valid !== i_valid || p_data !== i_data || p_last !== i_last ||
                      p_user !== i_user || p_ready !== 1'b1)) pass_err++;
    end

    task automatic send(input logic [2:0] ty, input int m, input int n, input int p);
        logic [63:0]      in_w[$];
        logic [63:0]      hin, hout;
        logic [OUT_W-1:0] w;
        bit               ts, mg;
        int               lb, pay, len, mo, lo, idx, cyc, grp;
        logic [USER_W-1:0] usr;
        bit               acc;
        ts  = (ty == 3'd7);
        mg  = (ty == 3'd1);
        lb  = (p % 8) + 1;
        usr = USER_W'(p);
        pay = mg ? n * 8 : (n - 1) * 8 + lb;
        len = 8 * (1 + int'(ts) + m) + pay;
        mo  = (m + 3) / 4;
        lo  = 32 * (1 + mo) + (mg ? n * 32 : pay);
        hin  = {40'(p * 13 + 7), ty, 5'(m), 16'(len)};
        hout = {40'(p * 13 + 7), ty, 5'(mo), 16'(lo)};
        in_w.push_back(hin);
        if (ts) in_w.push_back(dw(p, 1000));
        for (int i = 0; i < m; i++) in_w.push_back(dw(p, 100 + i));
        for (int i = 0; i < n; i++) in_w.push_back(dw(p, 200 + i));
        // expected header word: R1 R2 R3
        w = '0;
        w[63:0] = hout;
        if (ts) w[127:64] = dw(p, 1000);
        exp_d.push_back(w); exp_l.push_back(1'b0); exp_u.push_back(usr);
        exp_t.push_back("R1/R2/R3 header");
        // metadata: R4
        for (int g = 0; g < mo; g++) begin
            w = '0;
            for (int l = 0; l < 4; l++)
                if (g * 4 + l < m) w[l*64 +: 64] = dw(p, 100 + g * 4 + l);
            exp_d.push_back(w); exp_l.push_back(1'b0); exp_u.push_back(usr);
            exp_t.push_back("R4 metadata");
        end
        if (mg) begin
            // R6 R7
            for (int i = 0; i < n; i++) begin
                w = OUT_W'(dw(p, 200 + i));
                if (i == 0) w[47:45] = 3'd2;
                exp_d.push_back(w); exp_l.push_back(i == n - 1); exp_u.push_back(usr);
                exp_t.push_back("R6/R7 management");
            end
        end else begin
            // R5
            grp = (n + 3) / 4;
            for (int g = 0; g < grp; g++) begin
                w = '0;
                for (int l = 0; l < 4; l++)
                    if (g * 4 + l < n) w[l*64 +: 64] = dw(p, 200 + g * 4 + l);
                exp_d.push_back(w); exp_l.push_back(g == grp - 1); exp_u.push_back(usr);
                exp_t.push_back("R5 payload");
            end
        end
        idx = 0;
        cyc = 0;
        while (idx < in_w.size()) begin
            @(negedge clk); #0.5;
            if (in_stall > 0 && $urandom_range(0, 99) < in_stall) i_valid = 1'b0;
            else begin
                i_valid = 1'b1;
                i_data  = in_w[idx];
                i_last  = (idx == in_w.size() - 1);
                i_user  = usr;
            end
            #1;
            acc = i_valid && i_ready;
            @(posedge clk);
            cyc++;
            if (acc) idx++;
        end
        if (in_stall == 0 && out_stall == 0)
            chk(cyc == in_w.size(), "R9 throughput", OUT_W'(cyc), OUT_W'(in_w.size()));
    endtask

    task automatic drain_and_compare();
        int t = 0;
        @(negedge clk); #0.5;
        i_valid = 1'b0;
        while (got_d.size() < exp_d.size() && t < 2000) begin
            @(posedge clk); t++;
        end
        repeat (4) @(posedge clk);
        chk(got_d.size() == exp_d.size(), "R4/R5 beat count",
            OUT_W'(got_d.size()), OUT_W'(exp_d.size()));
        for (int k = 0; k < exp_d.size() && k < got_d.size(); k++) begin
            chk(got_d[k] === exp_d[k], exp_t[k], got_d[k], exp_d[k]);
            chk(got_l[k] === exp_l[k], {exp_t[k], " last flag"},
                OUT_W'(got_l[k]), OUT_W'(exp_l[k]));
            chk(got_u[k] === exp_u[k], "R8 user", OUT_W'(got_u[k]), OUT_W'(exp_u[k]));
        end
        exp_d.delete(); exp_l.delete(); exp_u.delete(); exp_t.delete();
        got_d.delete(); got_l.delete(); got_u.delete();
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        automatic logic [2:0] types[3] = '{3'd6, 3'd7, 3'd1};
        automatic int ms[7] = '{0, 1, 3, 4, 5, 8, 31};
        automatic int ns[6] = '{1, 2, 3, 4, 5, 9};
        automatic int ins[4]  = '{0, 50, 50, 0};
        automatic int outs[4] = '{0, 50, 0, 50};
        automatic int p = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10 during reset
        chk(o_valid == 1'b0, "R10 valid in reset", OUT_W'(o_valid), '0);
        chk(i_ready == 1'b1, "R10 ready in reset", OUT_W'(i_ready), OUT_W'(1));
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(o_valid == 1'b0, "R10 valid after reset", OUT_W'(o_valid), '0);
        chk(i_ready == 1'b1, "R10 ready after reset", OUT_W'(i_ready), OUT_W'(1));
        for (int mode = 0; mode < 4; mode++) begin
            in_stall  = ins[mode];
            out_stall = outs[mode];
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 7; b++)
                    for (int c = 0; c < 6; c++) begin
                        send(types[a], ms[b], ns[c], p);
                        p++;
                    end
            drain_and_compare();
        end
        // R11
        chk(pass_err == 0, "R11 pass-through", OUT_W'(pass_err), '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule